// File: doc/BRIEF.md
# Tick-Rate Divider with Source Select and Dual Gates

This block produces two slow tick strobes from one of four faster tick strobes, all within a single system clock domain. The strobes are one cycle wide. One 32-bit control word sets the behaviour. A 2-bit field picks which of the four input strobe streams feeds the block. A 4-bit field sets an integer ratio from 1 to 16. A flag adds a further fixed halving on the secondary output. Two gate bits let each output through or hold it silent.

Software updates the control word through a masked write port, so it can change one field without a read-modify-write. It can also use two command pulses that switch both gates on or off together. The whole word reads back continuously. An "on" indication is high while either gate is open.

Top module: `tick_rate_gen`

## Requirements
- R1: After reset the control word reads 0, both tick outputs are low and the on indication is low. This means gates closed, source 0, ratio 1.
- R2: A write replaces exactly those control bits whose mask bit is 1 and keeps every other bit. All 32 bits read back as held, including bits with no function.
- R3: Bits 25:24 select the source: value k takes ticks from input bit k (0 to 3), and ticks on the other inputs have no effect.
- R4: A pulse on `on_req` sets bits 31 and 15. A pulse on `off_req` clears both, and `off_req` wins when both pulses arrive together.
- R5: With bits 3:0 holding D, the primary output gives one tick for every D+1 ticks of the selected source. This gives ratios 1 to 16.
- R6: Each output tick is one cycle wide. It appears in the cycle after the source tick that completes the count.
- R7: With bit 11 set, the secondary output ticks on every second primary event. With bit 11 clear, it ticks together with every primary event.
- R8: Bit 31 lets the primary output tick and bit 15 lets the secondary output tick, each independently of the other.
- R9: A write whose mask touches bits 3:0 or 25:24 restarts the count, so the first tick after the change uses the new ratio and source.
- R10: While bits 31 and 15 are both clear, the count and the halving phase hold. Counting resumes from the held value once a gate opens.
- R11: `clk_on` is high exactly when bit 31 or bit 15 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control write strobe |
| wr_mask | input | 32 | Per-bit write mask |
| wr_data | input | 32 | Write data |
| on_req | input | 1 | Open both gates |
| off_req | input | 1 | Close both gates |
| src_tick | input | 4 | Source tick strobes, one per source |
| rd_data | output | 32 | Control word readback |
| clk_on | output | 1 | Either gate open |
| prim_tick | output | 1 | Primary divided tick |
| sec_tick | output | 1 | Secondary (optionally halved) tick |

## Verification
A control write or gate command takes effect at the next clock edge, so readback, `clk_on` and the gating are checked one cycle after the command. A source tick that completes the count shows on `prim_tick` and `sec_tick` one cycle later. The bench drives inputs and samples outputs on falling edges. It therefore counts a tick driven in one half-period exactly one falling edge later. Rate checks run a fixed number of source ticks and add one trailing cycle, so the last output tick falls inside the counting window.

// File: rtl/trg_pkg.sv
package trg_pkg;
   localparam int unsigned CTL_W      = 32;
   localparam int unsigned SEL_LO     = 24;
   localparam int unsigned SEL_W      = 2;
   localparam int unsigned DIV_LO     = 0;
   localparam int unsigned DIV_W      = 4;
   localparam int unsigned HALF_POS   = 11;
   localparam int unsigned GATE_P_POS = 31;
   localparam int unsigned GATE_S_POS = 15;

   // Mask of a field of width w starting at bit lo within a CTL_W word.
   function automatic logic [CTL_W-1:0] field_mask(input int unsigned lo, input int unsigned w);
      logic [CTL_W-1:0] m;
      m = '0;
      for (int unsigned i = 0; i < CTL_W; i++) begin
         if (i >= lo && i < lo + w) m[i] = 1'b1;
      end
      return m;
   endfunction
endpackage

// File: rtl/trg_ctl_reg.sv
module trg_ctl_reg
   import trg_pkg::*;
#(
   parameter int unsigned W      = CTL_W,
   parameter int unsigned S_LO   = SEL_LO,
   parameter int unsigned S_W    = SEL_W,
   parameter int unsigned D_LO   = DIV_LO,
   parameter int unsigned D_W    = DIV_W,
   parameter int unsigned H_POS  = HALF_POS,
   parameter int unsigned GP_POS = GATE_P_POS,
   parameter int unsigned GS_POS = GATE_S_POS
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic [W-1:0]   wr_mask,
   input  logic [W-1:0]   wr_data,
   input  logic           on_req,
   input  logic           off_req,
   output logic [W-1:0]   ctl_q,
   output logic [S_W-1:0] sel,
   output logic [D_W-1:0] div,
   output logic           half,
   output logic           gate_p,
   output logic           gate_s,
   output logic           reload
);
   localparam logic [W-1:0] RELOAD_MASK = W'(field_mask(S_LO, S_W) | field_mask(D_LO, D_W));

   if (S_LO + S_W > W || D_LO + D_W > W) begin : g_bad_field
      $error("trg_ctl_reg: field exceeds register width");
   end
   if (H_POS >= W || GP_POS >= W || GS_POS >= W || GP_POS == GS_POS) begin : g_bad_bit
      $error("trg_ctl_reg: flag bit position invalid");
   end

   logic [W-1:0] ctl_d;

   always_comb begin
      ctl_d = ctl_q;
      if (wr_en) ctl_d = (ctl_q & ~wr_mask) | (wr_data & wr_mask);
      if (on_req) begin
         ctl_d[GP_POS] = 1'b1;
         ctl_d[GS_POS] = 1'b1;
      end
      if (off_req) begin
         ctl_d[GP_POS] = 1'b0;
         ctl_d[GS_POS] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctl_q <= '0;
      else        ctl_q <= ctl_d;
   end

   assign sel    = ctl_q[S_LO +: S_W];
   assign div    = ctl_q[D_LO +: D_W];
   assign half   = ctl_q[H_POS];
   assign gate_p = ctl_q[GP_POS];
   assign gate_s = ctl_q[GS_POS];
   assign reload = wr_en && |(wr_mask & RELOAD_MASK);

   a_r2_field_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !on_req && !off_req) |=>
         ((ctl_q & ~$past(wr_mask)) == ($past(ctl_q) & ~$past(wr_mask))));
   a_r4_on_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (on_req && !off_req) |=> (gate_p && gate_s));
   a_r4_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
      off_req |=> (!gate_p && !gate_s));
endmodule

// File: rtl/trg_src_mux.sv
module trg_src_mux #(
   parameter int unsigned S_W = 2
) (
   input  logic [(1<<S_W)-1:0] src,
   input  logic [S_W-1:0]      sel,
   output logic                tick
);
   localparam int unsigned N = 1 << S_W;

   logic [N-1:0] hit;

   for (genvar k = 0; k < N; k++) begin : g_leg
      assign hit[k] = src[k] && (sel == S_W'(k));
   end

   assign tick = |hit;
endmodule

// File: rtl/trg_div_cnt.sv
module trg_div_cnt #(
   parameter int unsigned D_W = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           tick_in,
   input  logic           run,
   input  logic           reload,
   input  logic [D_W-1:0] div,
   output logic           fire
);
   if (D_W < 1) begin : g_bad_width
      $error("trg_div_cnt: divider width must be positive");
   end

   logic [D_W-1:0] cnt;

   assign fire = run && tick_in && !reload && (cnt == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt <= '0;
      else if (reload)          cnt <= '0;
      else if (run && tick_in)  cnt <= fire ? '0 : cnt + 1'b1;
   end

   a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= div);
   a_r9_reload_zero: assert property (@(posedge clk) disable iff (!rst_n)
      reload |=> (cnt == '0));
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !reload) |=> $stable(cnt));
endmodule

// File: rtl/trg_half_stage.sv
module trg_half_stage #(
   parameter bit HALF_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   input  logic reload,
   input  logic half,
   output logic sec_fire
);
   if (HALF_EN) begin : g_toggle
      logic phase;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     phase <= 1'b0;
         else if (reload) phase <= 1'b0;
         else if (fire)   phase <= ~phase;
      end
      assign sec_fire = half ? (fire && phase) : fire;
   end else begin : g_bypass
      assign sec_fire = fire;
   end

   a_r7_sec_subset: assert property (@(posedge clk) disable iff (!rst_n)
      sec_fire |-> fire);
endmodule

// File: rtl/tick_rate_gen.sv
module tick_rate_gen
   import trg_pkg::*;
#(
   parameter int unsigned W       = CTL_W,
   parameter int unsigned S_W     = SEL_W,
   parameter int unsigned D_W     = DIV_W,
   parameter bit          HALF_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [W-1:0]        wr_mask,
   input  logic [W-1:0]        wr_data,
   input  logic                on_req,
   input  logic                off_req,
   input  logic [(1<<S_W)-1:0] src_tick,
   output logic [W-1:0]        rd_data,
   output logic                clk_on,
   output logic                prim_tick,
   output logic                sec_tick
);
   logic [S_W-1:0] sel;
   logic [D_W-1:0] div;
   logic           half, gate_p, gate_s, reload;
   logic           sel_tick, fire, sec_fire, run;

   trg_ctl_reg #(.W(W), .S_W(S_W), .D_W(D_W)) u_ctl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mask(wr_mask), .wr_data(wr_data),
      .on_req(on_req), .off_req(off_req), .ctl_q(rd_data), .sel(sel), .div(div),
      .half(half), .gate_p(gate_p), .gate_s(gate_s), .reload(reload)
   );

   trg_src_mux #(.S_W(S_W)) u_mux (.src(src_tick), .sel(sel), .tick(sel_tick));

   assign run = gate_p || gate_s;

   trg_div_cnt #(.D_W(D_W)) u_div (
      .clk(clk), .rst_n(rst_n), .tick_in(sel_tick), .run(run), .reload(reload),
      .div(div), .fire(fire)
   );

   trg_half_stage #(.HALF_EN(HALF_EN)) u_half (
      .clk(clk), .rst_n(rst_n), .fire(fire), .reload(reload), .half(half),
      .sec_fire(sec_fire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prim_tick <= 1'b0;
         sec_tick  <= 1'b0;
      end else begin
         prim_tick <= fire && gate_p;
         sec_tick  <= sec_fire && gate_s;
      end
   end

   assign clk_on = run;

   a_r8_prim_gated: assert property (@(posedge clk) disable iff (!rst_n)
      prim_tick |-> $past(gate_p));
   a_r8_sec_gated: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |-> $past(gate_s));
   a_r11_on_flag: assert property (@(posedge clk) disable iff (!rst_n)
      clk_on == (rd_data[GATE_P_POS] || rd_data[GATE_S_POS]));
endmodule

// File: tb/tick_rate_gen_bench.sv
module tick_rate_gen_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_mask = '0;
   logic [31:0] wr_data = '0;
   logic        on_req = 1'b0;
   logic        off_req = 1'b0;
   logic [3:0]  src_tick = '0;
   logic [31:0] rd_data;
   logic        clk_on, prim_tick, sec_tick;

   int checks = 0;
   int fails  = 0;
   int n_prim, n_sec;
   bit done = 1'b0;

   always #5 clk = ~clk;

   tick_rate_gen u_tick_rate_gen (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mask(wr_mask), .wr_data(wr_data),
      .on_req(on_req), .off_req(off_req), .src_tick(src_tick), .rd_data(rd_data),
      .clk_on(clk_on), .prim_tick(prim_tick), .sec_tick(sec_tick)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [31:0] m, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_mask = m; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_mask = '0; wr_data = '0;
   endtask

   task automatic cmd(input bit on, input bit off);
      @(negedge clk);
      on_req = on; off_req = off;
      @(negedge clk);
      on_req = 1'b0; off_req = 1'b0;
   endtask

   // Drive n cycles; source s ticks when i % per[s] == 0 (per 0 = silent).
   task automatic run_ticks(input int n, input int p0, input int p1, input int p2, input int p3);
      int per [4];
      per = '{p0, p1, p2, p3};
      n_prim = 0; n_sec = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         n_prim += int'(prim_tick); n_sec += int'(sec_tick);
         for (int s = 0; s < 4; s++) src_tick[s] = (per[s] != 0) && (i % per[s] == 0);
      end
      @(negedge clk);
      n_prim += int'(prim_tick); n_sec += int'(sec_tick);
      src_tick = '0;
   endtask

   task automatic t_reset;
      chk("R1 readback", rd_data, 0);
      chk("R1 clk_on", clk_on, 0);
      chk("R1 ticks", {prim_tick, sec_tick}, 0);
   endtask

   task automatic t_fields;
      wr(32'hFFFF_FFFF, 32'h4A5A_25A5);
      chk("R2 full write", rd_data, 32'h4A5A_25A5);
      wr(32'h0000_000F, 32'h0000_0003);
      chk("R2 divider only", rd_data, 32'h4A5A_25A3);
      wr(32'h0000_0800, 32'h0000_0800);
      chk("R2 half only", rd_data, 32'h4A5A_2DA3);
      wr(32'h0300_0000, 32'h0100_0000);
      chk("R2 select only", rd_data, 32'h495A_2DA3);
      wr(32'hFFFF_FFFF, 32'h0);
   endtask

   task automatic t_gates_cmd;
      cmd(1'b1, 1'b0);
      chk("R4 on sets 31 and 15", rd_data, 32'h8000_8000);
      chk("R11 on flag", clk_on, 1);
      cmd(1'b1, 1'b1);
      chk("R4 off wins", rd_data, 32'h0);
      chk("R11 off flag", clk_on, 0);
      wr(32'h0000_8000, 32'h0000_8000);
      chk("R11 single gate", clk_on, 1);
      wr(32'h0000_8000, 32'h0);
   endtask

   task automatic t_ratio;
      wr(32'h0000_000F, 32'h3);
      cmd(1'b1, 1'b0);
      run_ticks(40, 1, 1, 1, 1);
      chk("R5 div4 primary", n_prim, 10);
      chk("R7 half clear follows", n_sec, 10);
      wr(32'h0000_0800, 32'h0000_0800);
      run_ticks(40, 1, 1, 1, 1);
      chk("R7 half primary", n_prim, 10);
      chk("R7 half secondary", n_sec, 5);
      wr(32'h0000_080F, 32'h0000_000F);
      run_ticks(64, 1, 1, 1, 1);
      chk("R5 div16", n_prim, 4);
      wr(32'h0000_000F, 32'h0);
      run_ticks(20, 1, 1, 1, 1);
      chk("R5 div1", n_prim, 20);
   endtask

   task automatic t_latency;
      @(negedge clk); src_tick = 4'b0001;
      @(negedge clk); src_tick = 4'b0000;
      chk("R6 tick next cycle", prim_tick, 1);
      @(negedge clk);
      chk("R6 one cycle wide", prim_tick, 0);
   endtask

   task automatic t_mux;
      wr(32'h0300_000F, 32'h0200_0000);
      run_ticks(30, 1, 1, 3, 1);
      chk("R3 source 2", n_prim, 10);
      wr(32'h0300_0000, 32'h0300_0000);
      run_ticks(30, 1, 1, 1, 5);
      chk("R3 source 3", n_prim, 6);
      wr(32'h0300_0000, 32'h0);
   endtask

   task automatic t_reload;
      wr(32'h0000_000F, 32'h7);
      run_ticks(3, 1, 0, 0, 0);
      chk("R9 before change", n_prim, 0);
      wr(32'h0000_000F, 32'h1);
      run_ticks(1, 1, 0, 0, 0);
      chk("R9 first after change", n_prim, 0);
      run_ticks(1, 1, 0, 0, 0);
      chk("R9 new ratio", n_prim, 1);
   endtask

   task automatic t_gating;
      wr(32'h8000_800F, 32'h8000_0000);
      run_ticks(10, 1, 0, 0, 0);
      chk("R8 primary open", n_prim, 10);
      chk("R8 secondary shut", n_sec, 0);
      wr(32'h8000_8000, 32'h0000_8000);
      run_ticks(10, 1, 0, 0, 0);
      chk("R8 primary shut", n_prim, 0);
      chk("R8 secondary open", n_sec, 10);
   endtask

   task automatic t_hold;
      wr(32'h0000_000F, 32'h3);
      cmd(1'b1, 1'b0);
      run_ticks(2, 1, 0, 0, 0);
      cmd(1'b0, 1'b1);
      run_ticks(10, 1, 0, 0, 0);
      chk("R10 silent while closed", n_prim + n_sec, 0);
      cmd(1'b1, 1'b0);
      run_ticks(1, 1, 0, 0, 0);
      chk("R10 third tick", n_prim, 0);
      run_ticks(1, 1, 0, 0, 0);
      chk("R10 resumes count", n_prim, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_fields();
      t_gates_cmd();
      t_ratio();
      t_latency();
      t_mux();
      t_reload();
      t_gating();
      t_hold();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule